// File: doc/BRIEF.md
# Trapezoidal Ring Cadence Controller

This block sits on the host side of a subscriber line interface circuit. It drives that circuit's four-bit mode word and its active-low strobe to make trapezoidal ringing. The line circuit shapes each polarity swap into a ramp. The controller only chooses which polarity is applied and when. During the ring-on part of a cadence it flips the polarity bit once per programmed half-period. During the silent part it parks the line in standby. The on/silent cycle repeats until a stop request arrives.

A ring-trip detector input, active low, reports that the subscriber has answered. When it goes low while ringing, toggling stops at once. The controller then writes the active normal-polarity word and raises a one-cycle answered pulse. All durations (half-period, ring-on time, silent time) are given in clock ticks.

Every word is presented to the line circuit in a fixed write cycle. The data is set up first, then the strobe is held low for a minimum time, then the data is held after the strobe is released. A request that arrives while a write is under way waits in a single pending slot. A newer request overwrites that slot, and the write already on the bus is never cut short.

Top module: `ring_cadence_ctrl`

## Requirements
- R1: After reset, cs_n is 1, ctl_word is 4'b0000 and answered is 0.
- R2: A start pulse while idle produces a first write of the normal ringing word, ctl_word = 4'b0001 (bit 0 set, all other bits clear; bit i of ctl_word is mode bit i).
- R3: While ringing, one write follows every half_period ticks. The writes alternate between the normal ringing word 4'b0001 and the reverse ringing word 4'b0101 (bit 2 is the polarity bit: 0 direct, 1 reverse). Ring-on therefore holds ceil(on_time/half_period) ringing writes.
- R4: on_time ticks after ring-on begins, the standby word 4'b0100 is written. off_time ticks later a new ring-on begins with the normal ringing word. The pattern repeats.
- R5: In every write the word is stable for SETUP_CYC cycles before cs_n falls. cs_n then stays low for exactly STROBE_CYC cycles. The word does not change for HOLD_CYC cycles after cs_n rises, and never changes while cs_n is low.
- R6: det_n low during ring-on causes, after the write in progress, a write of the active word 4'b0010 and exactly one one-cycle answered pulse. No further writes follow.
- R7: A stop request during ring-on lets the write in progress finish, then writes the standby word 4'b0100. No further writes follow.
- R8: det_n low during the silent part gives no answered pulse and no write. A stop during the silent part ends the cadence with no further writes. A start pulse while the cadence is running has no effect on the timing of the writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin a ring cadence |
| stop | input | 1 | One-cycle request to end the cadence |
| half_period | input | TW | Ring half-period in ticks |
| on_time | input | TW | Ring-on duration in ticks |
| off_time | input | TW | Silent duration in ticks |
| det_n | input | 1 | Ring-trip detect from the line circuit, active low, asynchronous |
| ctl_word | output | 4 | Mode word to the line circuit, bit i is mode bit i |
| cs_n | output | 1 | Write strobe, active low |
| answered | output | 1 | One-cycle pulse when ring trip is accepted |

## Verification
The cadence is run with several sets of half-period, on and off times. These include an on-time that is an exact multiple of the half-period, one that is not, and one equal to a single half-period. Together they separate a correct ceiling count of ringing writes from an off-by-one, and a correct polarity order from a stuck bit. The exact spacing between consecutive write completions tells a correct half-period from a drifting one, and a correct standby timing from a late one. Separate runs place ring trip, stop and a stray start inside ring-on, and ring trip and stop inside the silent part. These runs show that answered and the final word depend on the phase the request lands in.

// File: rtl/ring_cad_pkg.sv
package ring_cad_pkg;
  localparam logic [3:0] WORD_IDLE      = 4'b0000;
  localparam logic [3:0] WORD_RING_NORM = 4'b0001;
  localparam logic [3:0] WORD_RING_REV  = 4'b0101;
  localparam logic [3:0] WORD_STANDBY   = 4'b0100;
  localparam logic [3:0] WORD_ACTIVE    = 4'b0010;

  typedef enum logic [1:0] {SQ_IDLE, SQ_RING, SQ_SILENT} seq_state_t;
  typedef enum logic [1:0] {WR_IDLE, WR_SETUP, WR_STROBE, WR_HOLD} wr_phase_t;
endpackage

// File: rtl/ring_det_sync.sv
module ring_det_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/ring_word_writer.sv
module ring_word_writer
  import ring_cad_pkg::*;
#(
  parameter int SETUP_CYC  = 10,
  parameter int STROBE_CYC = 50,
  parameter int HOLD_CYC   = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req,
  input  logic [3:0] req_word,
  output logic       take,
  output logic [3:0] word_q,
  output logic       cs_n_q
);
  localparam int MAXC = (SETUP_CYC > STROBE_CYC) ?
                        ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC) :
                        ((STROBE_CYC > HOLD_CYC) ? STROBE_CYC : HOLD_CYC);
  localparam int CW = $clog2(MAXC + 1) + 1;

  wr_phase_t     phase;
  logic [CW-1:0] cnt;
  logic [CW-1:0] low_run;

  assign take = (phase == WR_IDLE) && req;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= WR_IDLE;
      cnt    <= '0;
      word_q <= WORD_IDLE;
      cs_n_q <= 1'b1;
    end else begin
      case (phase)
        WR_IDLE: if (req) begin
          word_q <= req_word;
          cnt    <= '0;
          phase  <= WR_SETUP;
        end
        WR_SETUP: if (cnt == CW'(SETUP_CYC - 1)) begin
          cs_n_q <= 1'b0;
          cnt    <= '0;
          phase  <= WR_STROBE;
        end else cnt <= cnt + 1'b1;
        WR_STROBE: if (cnt == CW'(STROBE_CYC - 1)) begin
          cs_n_q <= 1'b1;
          cnt    <= '0;
          phase  <= WR_HOLD;
        end else cnt <= cnt + 1'b1;
        WR_HOLD: if (cnt == CW'(HOLD_CYC - 1)) begin
          cnt   <= '0;
          phase <= WR_IDLE;
        end else cnt <= cnt + 1'b1;
        default: phase <= WR_IDLE;
      endcase
    end
  end

  // strobe-low run length, kept only for the width check
  always_ff @(posedge clk) begin
    if (rst || cs_n_q) low_run <= '0;
    else               low_run <= low_run + 1'b1;
  end

  assert_word_stable_R5: assert property (@(posedge clk) disable iff (rst)
    !cs_n_q |-> $stable(word_q));
  assert_strobe_width_R5: assert property (@(posedge clk) disable iff (rst)
    low_run <= CW'(STROBE_CYC));
  assert_strobe_setup_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n_q) |-> $stable(word_q));
endmodule

// File: rtl/ring_cadence_seq.sv
module ring_cadence_seq
  import ring_cad_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          stop,
  input  logic [TW-1:0] half_period,
  input  logic [TW-1:0] on_time,
  input  logic [TW-1:0] off_time,
  input  logic          det_s,
  input  logic          take,
  output logic          pend,
  output logic [3:0]    pend_word,
  output logic          answered
);
  seq_state_t    st, st_n;
  logic [TW-1:0] on_cnt, on_n, half_cnt, half_n, off_cnt, off_n;
  logic          pol, pol_n, issue, ans_n;
  logic [3:0]    issue_word;

  function automatic logic expired(input logic [TW-1:0] c, input logic [TW-1:0] lim);
    return ({1'b0, c} + 1'b1) >= {1'b0, lim};
  endfunction

  always_comb begin
    st_n = st; on_n = on_cnt; half_n = half_cnt; off_n = off_cnt; pol_n = pol;
    issue = 1'b0; issue_word = WORD_STANDBY; ans_n = 1'b0;
    case (st)
      SQ_IDLE: if (start) begin
        st_n = SQ_RING; on_n = '0; half_n = '0; pol_n = 1'b0;
        issue = 1'b1; issue_word = WORD_RING_NORM;
      end
      SQ_RING: begin
        if (!det_s) begin
          st_n = SQ_IDLE; issue = 1'b1; issue_word = WORD_ACTIVE; ans_n = 1'b1;
        end else if (stop) begin
          st_n = SQ_IDLE; issue = 1'b1; issue_word = WORD_STANDBY;
        end else if (expired(on_cnt, on_time)) begin
          st_n = SQ_SILENT; off_n = '0; issue = 1'b1; issue_word = WORD_STANDBY;
        end else begin
          on_n = on_cnt + 1'b1;
          if (expired(half_cnt, half_period)) begin
            half_n = '0; pol_n = ~pol; issue = 1'b1;
            issue_word = pol ? WORD_RING_NORM : WORD_RING_REV;
          end else half_n = half_cnt + 1'b1;
        end
      end
      SQ_SILENT: begin
        if (stop) st_n = SQ_IDLE;
        else if (expired(off_cnt, off_time)) begin
          st_n = SQ_RING; on_n = '0; half_n = '0; pol_n = 1'b0;
          issue = 1'b1; issue_word = WORD_RING_NORM;
        end else off_n = off_cnt + 1'b1;
      end
      default: st_n = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= SQ_IDLE; on_cnt <= '0; half_cnt <= '0; off_cnt <= '0; pol <= 1'b0;
      pend <= 1'b0; pend_word <= WORD_STANDBY; answered <= 1'b0;
    end else begin
      st <= st_n; on_cnt <= on_n; half_cnt <= half_n; off_cnt <= off_n; pol <= pol_n;
      answered <= ans_n;
      if (take) pend <= 1'b0;
      if (issue) begin
        pend      <= 1'b1;
        pend_word <= issue_word;
      end
    end
  end

  assert_answer_single_R6: assert property (@(posedge clk) disable iff (rst)
    answered |=> !answered);
  assert_answer_from_ring_R6: assert property (@(posedge clk) disable iff (rst)
    answered |-> $past(st == SQ_RING));
  assert_idle_no_toggle_R8: assert property (@(posedge clk) disable iff (rst)
    (st == SQ_IDLE && $past(st == SQ_IDLE)) |-> $stable(pol) || start);
endmodule

// File: rtl/ring_cadence_ctrl.sv
module ring_cadence_ctrl
  import ring_cad_pkg::*;
#(
  parameter int TW          = 16,
  parameter int SETUP_CYC   = 10,
  parameter int STROBE_CYC  = 50,
  parameter int HOLD_CYC    = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          stop,
  input  logic [TW-1:0] half_period,
  input  logic [TW-1:0] on_time,
  input  logic [TW-1:0] off_time,
  input  logic          det_n,
  output logic [3:0]    ctl_word,
  output logic          cs_n,
  output logic          answered
);
  logic       det_s, take, pend;
  logic [3:0] pend_word;

  ring_det_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(det_n), .dout(det_s));

  ring_cadence_seq #(.TW(TW)) u_seq (
    .clk(clk), .rst(rst), .start(start), .stop(stop),
    .half_period(half_period), .on_time(on_time), .off_time(off_time),
    .det_s(det_s), .take(take), .pend(pend), .pend_word(pend_word),
    .answered(answered));

  ring_word_writer #(.SETUP_CYC(SETUP_CYC), .STROBE_CYC(STROBE_CYC),
                     .HOLD_CYC(HOLD_CYC)) u_wr (
    .clk(clk), .rst(rst), .req(pend), .req_word(pend_word), .take(take),
    .word_q(ctl_word), .cs_n_q(cs_n));

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (cs_n && !answered));
endmodule

// File: tb/test_ring_cadence_ctrl.sv
module test_ring_cadence_ctrl;
  localparam int TW = 16, SU = 10, SC = 50, HD = 10;
  localparam logic [3:0] RN = 4'b0001, RR = 4'b0101, SB = 4'b0100, AC = 4'b0010;
  localparam int NV = 4;
  localparam int VH [NV] = '{100, 100, 150, 120};
  localparam int VN [NV] = '{400, 480, 150, 600};
  localparam int VM [NV] = '{300, 200, 250, 150};

  logic clk = 0, rst = 1, start = 0, stop = 0, det_n = 1;
  logic [TW-1:0] half_period = 100, on_time = 400, off_time = 300;
  logic [3:0] ctl_word;
  logic cs_n, answered;

  int checks = 0, failures = 0, cyc = 0;
  logic log_clr = 0;
  int wr_n = 0, viol = 0, ans_cnt = 0, ans_long = 0;
  logic [3:0] wr_word [64];
  int wr_cyc [64];
  logic prev_cs = 1, prev_ans = 0;
  logic [3:0] prev_word = 0;
  int chg_cyc = 0, fall_cyc = 0, rise_cyc = -1000;

  ring_cadence_ctrl #(.TW(TW), .SETUP_CYC(SU), .STROBE_CYC(SC), .HOLD_CYC(HD)) i_ring_cadence_ctrl (
    .clk(clk), .rst(rst), .start(start), .stop(stop), .half_period(half_period),
    .on_time(on_time), .off_time(off_time), .det_n(det_n), .ctl_word(ctl_word),
    .cs_n(cs_n), .answered(answered));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (log_clr) begin
      wr_n = 0; ans_cnt = 0; ans_long = 0;
    end
    if (!rst) begin
      if (ctl_word != prev_word) begin
        if (!cs_n || cyc - rise_cyc < HD) viol++;
        chg_cyc = cyc;
      end
      if (prev_cs && !cs_n) begin
        if (cyc - chg_cyc < SU) viol++;
        fall_cyc = cyc;
      end
      if (!prev_cs && cs_n) begin
        if (cyc - fall_cyc != SC) viol++;
        rise_cyc = cyc;
        if (wr_n < 64) begin wr_word[wr_n] = ctl_word; wr_cyc[wr_n] = cyc; end
        wr_n++;
      end
      if (answered) ans_cnt++;
      if (answered && prev_ans) ans_long++;
    end
    prev_word = ctl_word; prev_cs = cs_n; prev_ans = answered;
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; start = 0; stop = 0; det_n = 1;
    wait_cyc(3); rst = 0; log_clr = 1; wait_cyc(1); log_clr = 0;
  endtask

  task automatic pulse_start(); start = 1; @(negedge clk); start = 0; endtask
  task automatic pulse_stop();  stop = 1;  @(negedge clk); stop = 0;  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: reset state
    wait_cyc(3);
    check(cs_n == 1'b1, "R1 cs_n", cs_n, 1);
    check(ctl_word == 4'b0000, "R1 ctl_word", ctl_word, 0);
    check(answered == 1'b0, "R1 answered", answered, 0);

    // cadence table: two bursts then stop in the silent part
    for (int v = 0; v < NV; v++) begin
      int r, idx, gap;
      logic [3:0] ew;
      do_reset();
      half_period = TW'(VH[v]); on_time = TW'(VN[v]); off_time = TW'(VM[v]);
      r = (VN[v] + VH[v] - 1) / VH[v];
      pulse_start();
      wait_cyc(2 * VN[v] + VM[v] + 100);
      pulse_stop(); // lands in the second silent part (R8)
      wait_cyc(2 * (VN[v] + VM[v]) + 200);
      check(wr_n == 2 * r + 2, "R4/R8 write count", wr_n, 2 * r + 2);
      idx = 0;
      for (int b = 0; b < 2; b++) begin
        for (int k = 0; k <= r; k++) begin
          ew = (k == r) ? SB : ((k % 2) ? RR : RN);
          if (idx < wr_n && idx < 64)
            check(wr_word[idx] == ew, (k == 0 && b == 0) ? "R2 first word" :
                  ((k == r) ? "R4 standby word" : "R3 ring word"), wr_word[idx], ew);
          if (idx > 0 && idx < wr_n && idx < 64) begin
            gap = (k == 0) ? VM[v] : ((k == r) ? VN[v] - (r - 1) * VH[v] : VH[v]);
            check(wr_cyc[idx] - wr_cyc[idx-1] == gap, (k == 0) ? "R4 silent gap" :
                  ((k == r) ? "R4 ring-on length" : "R3 half-period"),
                  wr_cyc[idx] - wr_cyc[idx-1], gap);
          end
          idx++;
        end
      end
      check(ans_cnt == 0, "R8 no answer without trip", ans_cnt, 0);
    end

    // R6: ring trip during ring-on
    do_reset();
    half_period = 100; on_time = 1000; off_time = 200;
    pulse_start();
    wait_cyc(250);
    det_n = 0;
    wait_cyc(2000);
    check(wr_n == 4, "R6 write count", wr_n, 4);
    check(wr_word[0] == RN && wr_word[1] == RR && wr_word[2] == RN, "R6 ring words", wr_word[2], RN);
    check(wr_word[3] == AC, "R6 active word", wr_word[3], AC);
    check(ans_cnt == 1, "R6 answered count", ans_cnt, 1);
    check(ans_long == 0, "R6 answered width", ans_long, 0);
    det_n = 1;

    // R8: trip in silent part ignored, stop in silent ends cadence
    do_reset();
    half_period = 100; on_time = 200; off_time = 500;
    pulse_start();
    wait_cyc(400);
    det_n = 0; wait_cyc(50); det_n = 1;
    wait_cyc(150);
    pulse_stop();
    wait_cyc(1500);
    check(ans_cnt == 0, "R8 silent trip ignored", ans_cnt, 0);
    check(wr_n == 3, "R8 silent stop count", wr_n, 3);
    check(wr_word[2] == SB, "R8 last word standby", wr_word[2], SB);

    // R7: stop during ring-on; R8: stray start during ring-on
    do_reset();
    half_period = 100; on_time = 1000; off_time = 200;
    pulse_start();
    wait_cyc(149);
    pulse_start();
    wait_cyc(80);
    pulse_stop();
    wait_cyc(1500);
    check(wr_n == 4, "R7 write count", wr_n, 4);
    check(wr_word[2] == RN, "R7 write in progress kept", wr_word[2], RN);
    check(wr_word[3] == SB, "R7 standby after stop", wr_word[3], SB);
    check(wr_cyc[2] - wr_cyc[0] == 200, "R8 start ignored while running", wr_cyc[2] - wr_cyc[0], 200);
    check(wr_cyc[3] - wr_cyc[2] >= SU + SC + HD, "R7 no cut write", wr_cyc[3] - wr_cyc[2], SU + SC + HD);

    // R5: bus timing over all writes seen
    check(viol == 0, "R5 write timing", viol, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule